// File: doc/BRIEF.md
# Configurable User-Defined Cell Delineator

This block takes a byte stream of fixed-layout cells on a valid/ready interface, with a start marker on the first byte of each cell. It labels every byte with its field: user-defined extra header, standard 4-byte header, HEC octet, or payload. It passes the labelled bytes on through a single output register. It flags the final byte of each cell and holds the four standard header bytes of the most recent cell as one word.

The cell layout is set by two configuration inputs. The first is the length of the user-defined prefix, from 1 to 12 bytes. The value 0 selects the plain 53-byte cell, with HEC and no prefix. The second selects whether the HEC octet is present. A cell has the prefix first, then the 4 header bytes, then the optional HEC, then 48 payload bytes.

The block latches the configuration on each start marker, so a change made in the middle of a cell applies from the next cell. A start marker that comes too early, or a missing marker after a completed cell, raises a one-cycle framing error. After a missing marker the block discards bytes until the next marker.

Top module: `udc_delineator`

## Requirements
- R1: A cell is 52 + X + H bytes long, where X is the latched prefix length and H is 1 when HEC is present. `out_eoc` is high on exactly the last byte of a cell. With X = 0, HEC is always present and the cell is 53 bytes, whatever `cfg_hec_en` says.
- R2: `out_tag` encodes the field of each byte as 0 = extra header, 1 = standard header, 2 = HEC, 3 = payload. The fields appear in this order: X bytes of extra header, 4 header bytes, the HEC byte if present, then 48 payload bytes.
- R3: When X > 0 and `cfg_hec_en` is 0, no byte is tagged 2 and the payload follows the header directly. A `cfg_xhdr_len` value above 12 is treated as 12.
- R4: `hdr_word` holds the four standard header bytes of the latest cell, with the first byte in bits 31:24. It takes its new value in the same cycle that the fourth header byte is presented on the output, and it keeps that value until the next cell's fourth header byte.
- R5: The configuration inputs are sampled only on a byte that carries the start marker. Changing them in the middle of a cell does not alter that cell's tags or length.
- R6: A start marker on a byte that is not the first byte of a cell pulses `frame_err` for one cycle. The unfinished cell ends without `out_eoc`, and the marked byte starts a new cell.
- R7: A byte without a start marker that arrives right after a complete cell pulses `frame_err` once. That byte and any further unmarked bytes are discarded until a marked byte arrives. Unmarked bytes received after reset are discarded without an error.
- R8: While `out_valid` is high and `out_ready` is low, the output signals hold steady and `in_ready` is low. Every accepted byte that belongs to a cell is output exactly once, in order.
- R9: After reset, `out_valid` and `frame_err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_xhdr_len | input | 4 | Extra header length, 0 = standard cell |
| cfg_hec_en | input | 1 | HEC octet present (used when length > 0) |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_tag | output | 2 | Field of the output byte |
| out_eoc | output | 1 | Output byte is the last byte of its cell |
| hdr_word | output | 32 | Captured standard header of the latest cell |
| frame_err | output | 1 | One-cycle framing error pulse |

## Verification
The hardest case to reach is a configuration change in the middle of a cell while the output is stalled. If the design sampled the setting at the wrong moment, the tags would shift only for the bytes that follow the change. Directed cells switch the configuration ten bytes after the start marker while the output-ready signal toggles at random. The reference model applies a setting only at start markers, so any early pickup shows up as a tag or end-of-cell mismatch. Random cells that are cut short or run too long drive the early-marker and missing-marker paths, including back-to-back errors.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [1:0] {
    TAG_XHDR = 2'd0,
    TAG_HDR  = 2'd1,
    TAG_HEC  = 2'd2,
    TAG_PAY  = 2'd3
  } tag_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_IDLE = 2'd1,
    ST_CELL = 2'd2
  } seq_e;
endpackage

// File: rtl/udc_layout.sv
module udc_layout #(
  parameter int XW        = 4,
  parameter int IW        = 7,
  parameter int HDR_BYTES = 4,
  parameter int PAY_BYTES = 48
) (
  input  logic [IW-1:0]      idx,
  input  logic [XW-1:0]      xlen,
  input  logic               hec,
  output udc_pkg::tag_e      tag,
  output logic               last,
  output logic               hdr_last
);
  import udc_pkg::*;

  logic [IW-1:0] x_i;
  logic [IW-1:0] hdr_end;
  logic [IW-1:0] last_idx;

  always_comb begin
    x_i      = IW'(xlen);
    hdr_end  = x_i + IW'(HDR_BYTES);
    last_idx = hdr_end + IW'(PAY_BYTES - 1) + IW'(hec);
    if (idx < x_i)                tag = TAG_XHDR;
    else if (idx < hdr_end)       tag = TAG_HDR;
    else if (hec && idx == hdr_end) tag = TAG_HEC;
    else                          tag = TAG_PAY;
    last     = (idx == last_idx);
    hdr_last = (idx == hdr_end - IW'(1));
  end
endmodule

// File: rtl/udc_seq.sv
module udc_seq #(
  parameter int XW       = 4,
  parameter int IW       = 7,
  parameter int MAX_XHDR = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] cfg_x,
  input  logic          cfg_hec,
  input  logic          acc,
  input  logic          sof,
  input  logic          last,
  output logic          emit,
  output logic          err,
  output logic [XW-1:0] eff_x,
  output logic          eff_hec,
  output logic [IW-1:0] eff_idx
);
  import udc_pkg::*;

  seq_e          st;
  logic [IW-1:0] idx;
  logic [XW-1:0] lat_x;
  logic          lat_hec;
  logic [XW-1:0] clamp_x;
  logic          start;

  always_comb begin
    clamp_x = (cfg_x > XW'(MAX_XHDR)) ? XW'(MAX_XHDR) : cfg_x;
    start   = acc && sof;
    eff_x   = start ? clamp_x : lat_x;
    eff_hec = start ? ((clamp_x == '0) || cfg_hec) : lat_hec;
    eff_idx = start ? '0 : idx;
    emit    = acc && (sof || st == ST_CELL);
    err     = acc && ((sof && st == ST_CELL) || (!sof && st == ST_IDLE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HUNT;
      idx     <= '0;
      lat_x   <= '0;
      lat_hec <= 1'b1;
    end else if (emit) begin
      lat_x   <= eff_x;
      lat_hec <= eff_hec;
      if (last) begin
        st  <= ST_IDLE;
        idx <= '0;
      end else begin
        st  <= ST_CELL;
        idx <= eff_idx + IW'(1);
      end
    end else if (err) begin
      st <= ST_HUNT;
    end
  end
endmodule

// File: rtl/udc_delineator.sv
module udc_delineator #(
  parameter int MAX_XHDR  = 12,
  parameter int HDR_BYTES = 4,
  parameter int PAY_BYTES = 48,
  parameter int DW        = 8,
  localparam int XW       = $clog2(MAX_XHDR + 1),
  localparam int MAX_CELL = MAX_XHDR + HDR_BYTES + 1 + PAY_BYTES,
  localparam int IW       = $clog2(MAX_CELL + 1),
  localparam int HW       = HDR_BYTES * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] cfg_xhdr_len,
  input  logic          cfg_hec_en,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [1:0]    out_tag,
  output logic          out_eoc,
  output logic [HW-1:0] hdr_word,
  output logic          frame_err
);
  import udc_pkg::*;

  logic          acc;
  logic          emit;
  logic          err;
  logic [XW-1:0] eff_x;
  logic          eff_hec;
  logic [IW-1:0] eff_idx;
  tag_e          tag;
  logic          last;
  logic          hdr_last;
  logic [HW-1:0] hdr_sh;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  udc_seq #(.XW(XW), .IW(IW), .MAX_XHDR(MAX_XHDR)) u_seq (
    .clk(clk), .rst(rst), .cfg_x(cfg_xhdr_len), .cfg_hec(cfg_hec_en),
    .acc(acc), .sof(in_sof), .last(last), .emit(emit), .err(err),
    .eff_x(eff_x), .eff_hec(eff_hec), .eff_idx(eff_idx)
  );

  udc_layout #(.XW(XW), .IW(IW), .HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)) u_layout (
    .idx(eff_idx), .xlen(eff_x), .hec(eff_hec),
    .tag(tag), .last(last), .hdr_last(hdr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= 2'd0;
      out_eoc   <= 1'b0;
      hdr_word  <= '0;
      hdr_sh    <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= err;
      if (in_ready) begin
        out_valid <= emit;
        if (emit) begin
          out_data <= in_data;
          out_tag  <= tag;
          out_eoc  <= last;
          if (tag == TAG_HDR) begin
            hdr_sh <= {hdr_sh[HW-DW-1:0], in_data};
            if (hdr_last) hdr_word <= {hdr_sh[HW-DW-1:0], in_data};
          end
        end
      end
    end
  end
endmodule

// File: rtl/udc_delineator_chk.sv
module udc_delineator_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [1:0] out_tag,
  input logic       out_eoc
);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag) && $stable(out_eoc)));

  assert_stall_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_eoc_on_payload_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eoc) |-> (out_tag == 2'd3));

  assert_cell_starts_after_eoc_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eoc) |=> (!out_valid || out_tag == 2'd0 || out_tag == 2'd1));
endmodule

bind udc_delineator udc_delineator_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag), .out_eoc(out_eoc)
);

// File: tb/udc_delineator_tb.sv
module udc_delineator_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_xhdr_len = 4'd0;
  logic        cfg_hec_en = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [1:0]  out_tag;
  logic        out_eoc;
  logic [31:0] hdr_word;
  logic        frame_err;

  always #4 clk = ~clk;

  udc_delineator u_dut (
    .clk(clk), .rst(rst), .cfg_xhdr_len(cfg_xhdr_len), .cfg_hec_en(cfg_hec_en),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tag(out_tag), .out_eoc(out_eoc), .hdr_word(hdr_word), .frame_err(frame_err)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit wd_hit = 0;

  // stimulus item: {sof, hec, x[3:0], data[7:0]}
  logic [13:0] in_q[$];
  // expected output: {hdr[31:0], eoc, tag[1:0], data[7:0]}
  logic [42:0] exp_q[$];

  int          m_st = 0;  // 0 hunt, 1 between cells, 2 inside cell
  int          m_idx = 0;
  int          m_x = 0;
  bit          m_hec = 1;
  int          m_len = 53;
  logic [31:0] m_sh = '0;
  logic [31:0] m_hdr = '0;
  int          exp_err = 0;
  int          obs_err = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic add_cell(int x, bit hec, int n, int x2, bit hec2, int sw);
    for (int k = 0; k < n; k++) begin
      int cx = (k >= sw) ? x2 : x;
      bit ch = (k >= sw) ? hec2 : hec;
      in_q.push_back({(k == 0), ch, 4'(cx), 8'($urandom)});
    end
  endtask

  task automatic add_raw(int n);
    for (int k = 0; k < n; k++) in_q.push_back({1'b0, 1'b1, 4'd0, 8'($urandom)});
  endtask

  task automatic m_emit(logic [7:0] d);
    logic [1:0] t;
    bit e;
    if (m_idx < m_x) t = 2'd0;
    else if (m_idx < m_x + 4) t = 2'd1;
    else if (m_hec && m_idx == m_x + 4) t = 2'd2;
    else t = 2'd3;
    if (t == 2'd1) begin
      m_sh = {m_sh[23:0], d};
      if (m_idx == m_x + 3) m_hdr = m_sh;
    end
    e = (m_idx == m_len - 1);
    exp_q.push_back({m_hdr, e, t, d});
    if (e) begin m_st = 1; m_idx = 0; end
    else begin m_st = 2; m_idx++; end
  endtask

  task automatic model(logic [13:0] it);
    int x = int'(it[11:8]);
    if (it[13]) begin
      if (m_st == 2) exp_err++;
      m_x = (x > 12) ? 12 : x;
      m_hec = (m_x == 0) ? 1'b1 : it[12];
      m_len = 52 + m_x + int'(m_hec);
      m_idx = 0;
      m_emit(it[7:0]);
    end else if (m_st == 1) begin
      exp_err++;
      m_st = 0;
    end else if (m_st == 2) begin
      m_emit(it[7:0]);
    end
  endtask

  task automatic cycle_io(ref bit pend, ref logic [13:0] item, input string req);
    logic [42:0] e;
    @(negedge clk);
    out_ready = ($urandom % 4) != 0;
    if (!pend && in_q.size() > 0) begin item = in_q.pop_front(); pend = 1; end
    if (pend) begin
      in_valid = ($urandom % 4) != 0;
      in_sof = item[13];
      cfg_hec_en = item[12];
      cfg_xhdr_len = item[11:8];
      in_data = item[7:0];
    end else begin
      in_valid = 1'b0;
    end
    #1;
    if (frame_err) obs_err++;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8", {"unexpected byte in ", req}, out_data, 0);
      end else begin
        e = exp_q.pop_front();
        chk(out_data == e[7:0], "R8", {"data ", req}, out_data, e[7:0]);
        chk(out_tag == e[9:8], "R2", {"tag ", req}, out_tag, e[9:8]);
        chk(out_eoc == e[10], "R1", {"eoc ", req}, out_eoc, e[10]);
        chk(hdr_word == e[42:11], "R4", {"hdr_word ", req}, hdr_word, e[42:11]);
      end
    end
    if (in_valid && in_ready) begin model(item); pend = 0; end
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1;
      chk(0, "watchdog", "run did not finish", cyc, 150000);
    end
  endtask

  task automatic run(string req);
    bit pend = 0;
    logic [13:0] item = '0;
    while ((in_q.size() > 0 || pend || exp_q.size() > 0) && !wd_hit)
      cycle_io(pend, item, req);
    for (int k = 0; k < 3; k++) cycle_io(pend, item, req);
    chk(obs_err == exp_err, req, "frame_err pulse count", obs_err, exp_err);
    obs_err = 0;
    exp_err = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    chk(frame_err == 1'b0, "R9", "frame_err after reset", frame_err, 0);

    // R7: unmarked bytes after reset are dropped silently
    add_raw(5);
    run("R7");
    // R1: standard cell, HEC forced even with cfg_hec_en low
    add_cell(0, 0, 53, 0, 0, 99);
    add_cell(12, 1, 65, 12, 1, 99);
    run("R1");
    // R3: no HEC, and length above 12 clamps
    add_cell(1, 0, 53, 1, 0, 99);
    add_cell(15, 0, 64, 15, 0, 99);
    run("R3");
    // R5: configuration switched mid-cell applies at the next cell
    add_cell(12, 1, 65, 0, 0, 10);
    add_cell(0, 0, 53, 0, 0, 99);
    add_cell(3, 0, 55, 9, 1, 20);
    add_cell(9, 1, 62, 9, 1, 99);
    run("R5");
    // R6: early start marker
    add_cell(3, 1, 20, 3, 1, 99);
    add_cell(3, 1, 1, 3, 1, 99);
    add_cell(3, 1, 56, 3, 1, 99);
    run("R6");
    // R7: missing start marker after a complete cell
    add_cell(2, 0, 54, 2, 0, 99);
    add_raw(3);
    add_cell(2, 0, 54, 2, 0, 99);
    run("R7");
    // random mix, R8 backpressure throughout
    for (int c = 0; c < 60; c++) begin
      int x = $urandom % 16;
      bit h = $urandom % 2;
      int cx = (x > 12) ? 12 : x;
      int len = 52 + cx + ((cx == 0) ? 1 : int'(h));
      int r = $urandom % 8;
      int n = (r == 0) ? len - 1 - ($urandom % 10) : (r == 1) ? len + 1 + ($urandom % 3) : len;
      add_cell(x, h, n, $urandom % 16, $urandom % 2, $urandom % 70);
    end
    run("R8");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule